// File: doc/BRIEF.md
# Stateful Implication Logic Sequencer

This block holds a row of single-bit state cells that stand in for nonvolatile resistive devices, and computes Boolean functions directly inside that row. It has no separate result register: every gate writes its answer into a target cell, and that cell keeps it until it is overwritten. Each gate is built from short, ordered micro-steps. The two basic kinds are an unconditional clear and a conditional set (material implication, in which the target becomes `(not source) or target`). Two multi-input steps are added: a simultaneous conditional reset from several sources, and a simultaneous set of two targets. These let wide NOR gates and fan-out copies finish in a fixed number of steps.

A client puts one command on the command port: an opcode, two source indices, a source mask for the wide gates, one or two target indices and a literal bit. The command is accepted when `busy` is low. The sequencer then runs one micro-step per clock. A free-running slot parity interleaves wide NOR evaluations and OR-with-copy evaluations on alternate slots, as a pipelined fabric would, and delays the start of such a gate by one cycle when the parity does not match. A command that names the same cell as both a source and a target is refused.

Top module: `slp_seq`

## Requirements
- R1: After a synchronous active-high reset, every cell reads 0, `busy` is 0, `err` is 0 and `sched_odd` is 0.
- R2: Opcode 0 (clear) writes 0 to cell `cmd_dst`. Opcode 1 (implication) writes `~cell[cmd_src_a] | cell[cmd_dst]` to `cmd_dst`. Each takes one step.
- R3: Opcode 7 (load) writes `cmd_bit` into cell `cmd_dst` in one step.
- R4: Opcode 2 (NAND) runs three steps in order: clear the target, implication from `cmd_src_a`, implication from `cmd_src_b`. The target ends as `~(a & b)`.
- R5: Opcode 3 (NOR) sets the target to 1, then in one step clears it if any cell selected by `cmd_mask` is 1. It always takes two steps, whatever number of mask bits is set.
- R6: `sched_odd` toggles on every clock after reset. The evaluating step of a NOR always runs on a clock edge where `sched_odd` was 1. The evaluating step of an OR-copy always runs where it was 0. When the parity does not match, the first step waits one cycle.
- R7: Opcode 4 (OR-copy) clears both `cmd_dst` and `cmd_dst2` in one step. In the next step it sets both, at the same time, to the OR of the cells selected by `cmd_mask`.
- R8: Opcode 5 (XOR) clears the target in a reset step, then sets it where `cell[a]` and `cell[b]` differ. The result is `a ^ b` after two steps.
- R9: Opcode 6 (XNOR) runs three steps: reset the target to 0, set it to 1, then clear it if `cell[a]` and `cell[b]` differ. The result is `~(a ^ b)`.
- R10: A command is accepted on a clock edge where `cmd_valid` is 1 and `busy` is 0. `busy` is high from the next cycle until the edge that runs the last step. `cmd_valid` while `busy` is high is ignored, and cells change only during steps.
- R11: Some commands reuse a cell as both source and target: implication with `cmd_src_a == cmd_dst`; NAND, XOR or XNOR with `cmd_dst` equal to either source; NOR with `cmd_mask[cmd_dst]` set; OR-copy with either target in the mask or with `cmd_dst == cmd_dst2`. Such a command raises `err` for exactly one cycle, leaves `busy` low and changes no cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode (0 clear, 1 implication, 2 NAND, 3 NOR, 4 OR-copy, 5 XOR, 6 XNOR, 7 load) |
| cmd_src_a | input | IW | First source cell index |
| cmd_src_b | input | IW | Second source cell index |
| cmd_mask | input | NCELL | Source selection for NOR and OR-copy |
| cmd_dst | input | IW | Target cell index |
| cmd_dst2 | input | IW | Second target for OR-copy |
| cmd_bit | input | 1 | Literal bit for load |
| busy | output | 1 | Macro operation in progress |
| err | output | 1 | One-cycle pulse for a refused command |
| sched_odd | output | 1 | Current slot parity |
| cells | output | NCELL | State of every cell |

## Verification
The checker assumes that the client drives `cmd_valid` only with defined fields and that no cell changes except through steps. It also assumes that a command raised while `busy` is high may be held or dropped without effect. The stimulus changes inputs only between clock edges. It waits for `busy` to fall before most commands, and presents a command during `busy` on purpose exactly once, to show that it is ignored. Index conflicts are created only by the specific operand choices listed in R11, so a correct design never raises `err` on the other commands.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [2:0] {
        OP_CLR   = 3'd0,
        OP_IMP   = 3'd1,
        OP_NAND  = 3'd2,
        OP_NOR   = 3'd3,
        OP_ORDUP = 3'd4,
        OP_XOR   = 3'd5,
        OP_XNOR  = 3'd6,
        OP_LOAD  = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        U_IDLE,
        U_CLEAR,
        U_SET,
        U_IMP_A,
        U_IMP_B,
        U_RST_ANY,
        U_SET_ANY,
        U_SET_DIFF,
        U_RST_DIFF,
        U_LOAD
    } ustep_e;

    localparam int STEP_W = 2;

    // number of micro-steps of a macro operation
    function automatic logic [STEP_W-1:0] op_len(op_e op);
        case (op)
            OP_NAND, OP_XNOR:           return 2'd3;
            OP_NOR, OP_ORDUP, OP_XOR:   return 2'd2;
            default:                    return 2'd1;
        endcase
    endfunction

    // micro-step kind for step number idx of op
    function automatic ustep_e op_step(op_e op, logic [STEP_W-1:0] idx);
        ustep_e k;
        k = U_IDLE;
        case (op)
            OP_CLR:   k = U_CLEAR;
            OP_IMP:   k = U_IMP_A;
            OP_LOAD:  k = U_LOAD;
            OP_NAND:  k = (idx == 2'd0) ? U_CLEAR : (idx == 2'd1) ? U_IMP_A : U_IMP_B;
            OP_NOR:   k = (idx == 2'd0) ? U_SET   : U_RST_ANY;
            OP_ORDUP: k = (idx == 2'd0) ? U_CLEAR : U_SET_ANY;
            OP_XOR:   k = (idx == 2'd0) ? U_CLEAR : U_SET_DIFF;
            OP_XNOR:  k = (idx == 2'd0) ? U_CLEAR : (idx == 2'd1) ? U_SET : U_RST_DIFF;
            default:  k = U_IDLE;
        endcase
        return k;
    endfunction

    // {constrained, parity the first step must see}
    function automatic logic [1:0] op_first_slot(op_e op);
        case (op)
            OP_NOR:   return 2'b10;  // evaluation then lands on odd
            OP_ORDUP: return 2'b11;  // evaluation then lands on even
            default:  return 2'b00;
        endcase
    endfunction

    // next value of one targeted cell
    function automatic logic cell_next(ustep_e k, logic cur, logic sa, logic sb,
                                       logic any_src, logic lit);
        case (k)
            U_CLEAR:    return 1'b0;
            U_SET:      return 1'b1;
            U_IMP_A:    return cur | ~sa;
            U_IMP_B:    return cur | ~sb;
            U_RST_ANY:  return cur & ~any_src;
            U_SET_ANY:  return cur | any_src;
            U_SET_DIFF: return cur | (sa ^ sb);
            U_RST_DIFF: return cur & ~(sa ^ sb);
            U_LOAD:     return lit;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/slp_check.sv
module slp_check
    import slp_pkg::*;
#(
    parameter int NCELL = 16,
    localparam int IW = $clog2(NCELL)
) (
    input  op_e              op,
    input  logic [IW-1:0]    src_a,
    input  logic [IW-1:0]    src_b,
    input  logic [IW-1:0]    dst,
    input  logic [IW-1:0]    dst2,
    input  logic [NCELL-1:0] mask,
    output logic             bad
);
    logic hit_a, hit_b;

    assign hit_a = (dst == src_a);
    assign hit_b = (dst == src_b);

    always_comb begin
        case (op)
            OP_IMP:                   bad = hit_a;
            OP_NAND, OP_XOR, OP_XNOR: bad = hit_a | hit_b;
            OP_NOR:                   bad = mask[dst];
            OP_ORDUP:                 bad = mask[dst] | mask[dst2] | (dst == dst2);
            default:                  bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cmd_valid,
    input  op_e    cmd_op,
    input  logic   cmd_bad,
    output logic   take,
    output logic   busy,
    output logic   err,
    output logic   sched_odd,
    output logic   step_fire,
    output ustep_e step_kind,
    output op_e    op_q
);
    logic [STEP_W-1:0] idx_q;
    logic [1:0]        slot_rule;
    logic              slot_ok;
    logic              accept;

    assign accept    = cmd_valid && !busy;
    assign take      = accept && !cmd_bad;
    assign slot_rule = op_first_slot(op_q);
    assign slot_ok   = (idx_q != '0) || !slot_rule[1] || (slot_rule[0] == sched_odd);
    assign step_fire = busy && slot_ok;
    assign step_kind = step_fire ? op_step(op_q, idx_q) : U_IDLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            err       <= 1'b0;
            sched_odd <= 1'b0;
            idx_q     <= '0;
            op_q      <= OP_CLR;
        end else begin
            sched_odd <= ~sched_odd;
            err       <= accept && cmd_bad;
            if (take) begin
                busy  <= 1'b1;
                op_q  <= cmd_op;
                idx_q <= '0;
            end else if (step_fire) begin
                idx_q <= idx_q + 1'b1;
                if (idx_q == op_len(op_q) - 1'b1)
                    busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/slp_cells.sv
module slp_cells
    import slp_pkg::*;
#(
    parameter int NCELL = 16,
    localparam int IW = $clog2(NCELL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  ustep_e           kind,
    input  logic             dual,
    input  logic [IW-1:0]    src_a,
    input  logic [IW-1:0]    src_b,
    input  logic [IW-1:0]    dst,
    input  logic [IW-1:0]    dst2,
    input  logic [NCELL-1:0] mask,
    input  logic             lit,
    output logic [NCELL-1:0] state
);
    logic [NCELL-1:0] nxt;
    logic             sa, sb, any_src;

    assign sa      = state[src_a];
    assign sb      = state[src_b];
    assign any_src = |(state & mask);

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        logic hit;
        assign hit    = (dst == IW'(i)) || (dual && (dst2 == IW'(i)));
        assign nxt[i] = hit ? cell_next(kind, state[i], sa, sb, any_src, lit) : state[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= '0;
        else if (fire)
            state <= nxt;
    end
endmodule

// File: rtl/slp_seq.sv
module slp_seq
    import slp_pkg::*;
#(
    parameter int NCELL = 16,
    localparam int IW = $clog2(NCELL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [IW-1:0]    cmd_src_a,
    input  logic [IW-1:0]    cmd_src_b,
    input  logic [NCELL-1:0] cmd_mask,
    input  logic [IW-1:0]    cmd_dst,
    input  logic [IW-1:0]    cmd_dst2,
    input  logic             cmd_bit,
    output logic             busy,
    output logic             err,
    output logic             sched_odd,
    output logic [NCELL-1:0] cells
);
    op_e              op_in, op_q;
    logic             bad, take, step_fire;
    ustep_e           step_kind;
    logic [IW-1:0]    a_q, b_q, d_q, d2_q;
    logic [NCELL-1:0] mask_q;
    logic             bit_q;

    assign op_in = op_e'(cmd_op);

    slp_check #(.NCELL(NCELL)) u_check (
        .op(op_in), .src_a(cmd_src_a), .src_b(cmd_src_b),
        .dst(cmd_dst), .dst2(cmd_dst2), .mask(cmd_mask), .bad(bad)
    );

    slp_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(op_in),
        .cmd_bad(bad), .take(take), .busy(busy), .err(err),
        .sched_odd(sched_odd), .step_fire(step_fire), .step_kind(step_kind),
        .op_q(op_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            d_q    <= '0;
            d2_q   <= '0;
            mask_q <= '0;
            bit_q  <= 1'b0;
        end else if (take) begin
            a_q    <= cmd_src_a;
            b_q    <= cmd_src_b;
            d_q    <= cmd_dst;
            d2_q   <= cmd_dst2;
            mask_q <= cmd_mask;
            bit_q  <= cmd_bit;
        end
    end

    slp_cells #(.NCELL(NCELL)) u_cells (
        .clk(clk), .rst(rst), .fire(step_fire), .kind(step_kind),
        .dual(op_q == OP_ORDUP), .src_a(a_q), .src_b(b_q), .dst(d_q),
        .dst2(d2_q), .mask(mask_q), .lit(bit_q), .state(cells)
    );
endmodule

// File: rtl/slp_seq_chk.sv
module slp_seq_chk
    import slp_pkg::*;
#(
    parameter int NCELL = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             busy,
    input logic             err,
    input logic             sched_odd,
    input logic [NCELL-1:0] cells,
    input logic             step_fire,
    input ustep_e           step_kind
);
    a_r6_slot_toggle: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sched_odd != $past(sched_odd)));

    a_r6_nor_eval_odd: assert property (@(posedge clk) disable iff (rst)
        (step_kind == U_RST_ANY) |-> sched_odd);

    a_r7_dup_eval_even: assert property (@(posedge clk) disable iff (rst)
        (step_kind == U_SET_ANY) |-> !sched_odd);

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cmd_valid) |=> $stable(cells));

    a_r10_step_needs_busy: assert property (@(posedge clk) disable iff (rst)
        step_fire |-> busy);

    a_r11_reject_quiet: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && $stable(cells)));
endmodule

bind slp_seq slp_seq_chk #(.NCELL(NCELL)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy), .err(err),
    .sched_odd(sched_odd), .cells(cells), .step_fire(step_fire),
    .step_kind(step_kind)
);

// File: tb/tb_slp_seq.sv
module tb_slp_seq;
    localparam int N  = 16;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [IW-1:0] cmd_src_a = '0, cmd_src_b = '0, cmd_dst = '0, cmd_dst2 = '0;
    logic [N-1:0]  cmd_mask = '0;
    logic          cmd_bit = 1'b0;
    logic          busy, err, sched_odd;
    logic [N-1:0]  cells;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    slp_seq #(.NCELL(N)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_mask(cmd_mask),
        .cmd_dst(cmd_dst), .cmd_dst2(cmd_dst2), .cmd_bit(cmd_bit),
        .busy(busy), .err(err), .sched_odd(sched_odd), .cells(cells)
    );

    // behavioural reference model
    logic [N-1:0] m_cells = '0;
    logic         m_busy = 1'b0, m_err = 1'b0, m_odd = 1'b0;
    logic [N-1:0] q[$];
    int           need = -1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_bad();
        case (cmd_op)
            3'd1:             return cmd_dst == cmd_src_a;
            3'd2, 3'd5, 3'd6: return (cmd_dst == cmd_src_a) || (cmd_dst == cmd_src_b);
            3'd3:             return cmd_mask[cmd_dst];
            3'd4:             return cmd_mask[cmd_dst] || cmd_mask[cmd_dst2] || (cmd_dst == cmd_dst2);
            default:          return 1'b0;
        endcase
    endfunction

    task automatic build();
        logic [N-1:0] c, v;
        logic a, b, anyv;
        c = m_cells; a = c[cmd_src_a]; b = c[cmd_src_b]; anyv = |(c & cmd_mask);
        v = c;
        case (cmd_op)
            3'd0: begin v[cmd_dst] = 1'b0; q.push_back(v); end
            3'd1: begin v[cmd_dst] = ~a | c[cmd_dst]; q.push_back(v); end
            3'd7: begin v[cmd_dst] = cmd_bit; q.push_back(v); end
            3'd2: begin
                v[cmd_dst] = 1'b0;     q.push_back(v);
                v[cmd_dst] = ~a;       q.push_back(v);
                v[cmd_dst] = ~(a & b); q.push_back(v);
            end
            3'd3: begin
                need = 0;
                v[cmd_dst] = 1'b1;  q.push_back(v);
                v[cmd_dst] = ~anyv; q.push_back(v);
            end
            3'd4: begin
                need = 1;
                v[cmd_dst] = 1'b0; v[cmd_dst2] = 1'b0; q.push_back(v);
                v[cmd_dst] = anyv; v[cmd_dst2] = anyv; q.push_back(v);
            end
            3'd5: begin
                v[cmd_dst] = 1'b0;  q.push_back(v);
                v[cmd_dst] = a ^ b; q.push_back(v);
            end
            default: begin
                v[cmd_dst] = 1'b0;     q.push_back(v);
                v[cmd_dst] = 1'b1;     q.push_back(v);
                v[cmd_dst] = ~(a ^ b); q.push_back(v);
            end
        endcase
    endtask

    task automatic model_step();
        bit acc;
        acc = cmd_valid && !m_busy;
        m_err = 1'b0;
        if (q.size() > 0 && (need < 0 || need == int'(m_odd))) begin
            m_cells = q.pop_front();
            need = -1;
        end
        if (acc) begin
            if (is_bad()) m_err = 1'b1;
            else build();
        end
        m_busy = q.size() > 0;
        m_odd  = ~m_odd;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        chk(cells == m_cells, "R10 model cells", 32'(cells), 32'(m_cells));
        chk(busy == m_busy, "R10 model busy", 32'(busy), 32'(m_busy));
        chk(err == m_err, "R11 model err", 32'(err), 32'(m_err));
        chk(sched_odd == m_odd, "R6 model slot", 32'(sched_odd), 32'(m_odd));
    endtask

    task automatic issue(input logic [2:0] op, input int a, input int b, input logic [N-1:0] m,
                         input int d, input int d2, input logic bv);
        cmd_op = op; cmd_src_a = IW'(a); cmd_src_b = IW'(b); cmd_mask = m;
        cmd_dst = IW'(d); cmd_dst2 = IW'(d2); cmd_bit = bv; cmd_valid = 1'b1;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic drain(output int n);
        n = 0;
        while (m_busy) begin tick(); n++; end
    endtask

    task automatic load(input int d, input logic bv);
        int n;
        issue(3'd7, 0, 0, '0, d, 0, bv);
        drain(n);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk(cells == '0 && !busy && !err && !sched_odd, "R1 reset state",
            {busy, err, sched_odd, 13'd0, cells}, 32'd0);

        // R3 load
        load(0, 1'b1); load(1, 1'b0); load(2, 1'b1); load(3, 1'b1);
        chk(cells[3:0] == 4'b1101, "R3 load pattern", 32'(cells[3:0]), 32'hd);

        // R2 implication truth table and clear
        for (int s = 0; s < 2; s++) begin
            for (int t = 0; t < 2; t++) begin
                load(4, s[0]); load(5, t[0]);
                issue(3'd1, 4, 0, '0, 5, 0, 1'b0); drain(n);
                chk(cells[5] == (~s[0] | t[0]), "R2 implication", 32'(cells[5]), 32'(~s[0] | t[0]));
            end
        end
        issue(3'd0, 0, 0, '0, 0, 0, 1'b0); drain(n);
        chk(cells[0] == 1'b0, "R2 clear", 32'(cells[0]), 32'd0);

        // R4 NAND, R8 XOR, R9 XNOR over all input pairs
        for (int p = 0; p < 4; p++) begin
            load(6, p[1]); load(7, p[0]);
            issue(3'd2, 6, 7, '0, 8, 0, 1'b0); drain(n);
            chk(cells[8] == ~(p[1] & p[0]) && n == 3, "R4 nand", {n[15:0], 15'd0, cells[8]},
                {16'd3, 15'd0, ~(p[1] & p[0])});
            issue(3'd5, 6, 7, '0, 9, 0, 1'b0); drain(n);
            chk(cells[9] == (p[1] ^ p[0]) && n == 2, "R8 xor", {n[15:0], 15'd0, cells[9]},
                {16'd2, 15'd0, p[1] ^ p[0]});
            issue(3'd6, 6, 7, '0, 10, 0, 1'b0); drain(n);
            chk(cells[10] == ~(p[1] ^ p[0]) && n == 3, "R9 xnor", {n[15:0], 15'd0, cells[10]},
                {16'd3, 15'd0, ~(p[1] ^ p[0])});
        end

        // R5 NOR with 2 and 5 inputs, both slot parities
        load(11, 1'b0); load(12, 1'b0); load(13, 1'b0);
        issue(3'd3, 0, 0, 16'h1800, 14, 0, 1'b0); drain(n);
        chk(cells[14] == 1'b1 && n <= 3, "R5 nor2 all zero", {n[15:0], 15'd0, cells[14]}, 32'd1);
        tick();
        issue(3'd3, 0, 0, 16'h3806, 14, 0, 1'b0); drain(n);
        chk(cells[14] == 1'b0 && n <= 3, "R5 nor5 one set", {n[15:0], 15'd0, cells[14]}, 32'd0);

        // R7 OR-copy to two targets
        issue(3'd4, 0, 0, 16'h3000, 15, 0, 1'b0); drain(n);
        chk(cells[15] == 1'b0 && cells[0] == 1'b0, "R7 orcopy zero", 32'(cells), 32'(m_cells));
        tick();
        issue(3'd4, 0, 0, 16'h000c, 15, 0, 1'b0); drain(n);
        chk(cells[15] && cells[0], "R7 orcopy one", {30'd0, cells[15], cells[0]}, 32'd3);

        // R10 command during busy is ignored
        issue(3'd2, 6, 7, '0, 8, 0, 1'b0);
        cmd_op = 3'd7; cmd_dst = IW'(1); cmd_bit = 1'b1; cmd_valid = 1'b1;
        tick();
        cmd_valid = 1'b0;
        drain(n);
        chk(cells[1] == 1'b0, "R10 ignored while busy", 32'(cells[1]), 32'd0);

        // R11 conflicts
        issue(3'd1, 5, 0, '0, 5, 0, 1'b0);
        chk(err && !busy, "R11 imp self", {30'd0, err, busy}, 32'd2);
        tick();
        issue(3'd2, 6, 8, '0, 8, 0, 1'b0);
        chk(err && !busy, "R11 nand self", {30'd0, err, busy}, 32'd2);
        tick();
        issue(3'd3, 0, 0, 16'h4001, 14, 0, 1'b0);
        chk(err, "R11 nor mask target", 32'(err), 32'd1);
        tick();
        issue(3'd4, 0, 0, 16'h0004, 9, 9, 1'b0);
        chk(err, "R11 orcopy same targets", 32'(err), 32'd1);
        tick();
        chk(!err, "R11 err one cycle", 32'(err), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule